// File: doc/BRIEF.md
# Multi-Event Circular Data Buffer

This block stores finished event records in a circular word memory. Acquisition can therefore continue while earlier events are still being drained. The writer streams the data words of one event and then closes it. When the event closes, the block fills in a header slot that was reserved at the start of that event. The header records the event tag, the module address and the number of data words. The reader takes words in order through a valid/ready port, starting with the header of the oldest event and then its data. A skip command throws away whatever is left of the oldest event.

Two limits apply at the same time. One is the number of stored events, set by `MAX_EVT`. The other is the number of memory words, set by `DEPTH`. The block raises a full indication whenever it cannot accept another word. Each committed event gets a 4-bit tag that wraps modulo 16. A module upstream can use the tag to check that several buffers stay in step. An event that is still open can be aborted. The reader never sees an open or aborted event.

Top module: `evt_ring_buf`

## Requirements
- R1: While reset is asserted, `evt_avail_o` and `full_o` are 0 and `wr_ready_o` is 1.
- R2: A data word is read out as bit 31 = 0 and bits 30:0 = the written payload. Data words follow their header in write order.
- R3: The header layout is: bit 31 = 1, bits 30:27 = tag, bits 26:22 = `mod_addr_i` sampled at close, bits 21:7 = 0, bits 6:0 = count of data words.
- R4: The first event committed after reset has tag 0. Each later committed event takes the previous tag plus 1, modulo 16.
- R5: Data words of an open event are invisible to the reader. `evt_avail_o` rises in the cycle after an accepted close.
- R6: `abort_i` drops every word of the open event and does not advance the tag.
- R7: `skip_i` with an event available drops the rest of the head event, including a partly read one. The next event's header becomes the read word.
- R8: While `MAX_EVT` events are stored, `full_o` = 1, `wr_ready_o` = 0, and a close is ignored (no event created, tag unchanged).
- R9: A data word is accepted only if, after storing it, the stored words, the open header slot and the open data words still fit in `DEPTH`. Otherwise `full_o` = 1 and the word is dropped.
- R10: `evt_avail_o` is 1 exactly when at least one committed event has not been fully read or skipped. A pop (`rd_ready_i` while available) advances one word.
- R11: If `close_i` and `wr_valid_i` are high in the same cycle, the data word is dropped. If `abort_i` and `close_i` are high in the same cycle, the abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_addr_i | input | 5 | Module address placed in the header |
| wr_valid_i | input | 1 | Data word present |
| wr_data_i | input | 31 | Data word payload |
| wr_ready_o | output | 1 | A data word would be accepted |
| close_i | input | 1 | Commit the open event |
| abort_i | input | 1 | Discard the open event |
| rd_data_o | output | 32 | Word at the read position |
| rd_ready_i | input | 1 | Pop the current read word |
| skip_i | input | 1 | Discard the rest of the head event |
| evt_avail_o | output | 1 | At least one committed event is unread; read word valid |
| full_o | output | 1 | No further word can be accepted |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Aborted events: a buffer that advanced the tag on abort would show a gap in the tag sequence.
- Zero-length events: a slip in header back-filling would corrupt the count field.
- Close and data in the same cycle: mishandling this would store a stray word.
- Skip in the middle of an event: a skip that miscounts the event length would leave the read position inside data rather than on a header.
- Event-count limit: the bench fills to the limit and issues one extra close. Accepting that close would push a tag past the expected 13.
- Word limit and tag wrap: the bench fills a single event up to the word limit and checks the 63-word count. It also wraps the tag past 15.

// File: rtl/evt_buf_pkg.sv
package evt_buf_pkg;
  localparam int WORD_W  = 32;
  localparam int TAG_W   = 4;
  localparam int MADDR_W = 5;
  localparam int CNT_W   = 7;
  localparam int PAD_W   = WORD_W - 1 - TAG_W - MADDR_W - CNT_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic               is_hdr;
    logic [TAG_W-1:0]   tag;
    logic [MADDR_W-1:0] maddr;
    logic [PAD_W-1:0]   pad;
    logic [CNT_W-1:0]   cnt;
  } hdr_t;
endpackage

// File: rtl/evt_mem.sv
module evt_mem
  import evt_buf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  word_t            wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output word_t            rdata_o,
  input  logic [AW-1:0]    haddr_i,
  output logic [CNT_W-1:0] hcnt_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
  assign hcnt_o  = mem_q[haddr_i][CNT_W-1:0];
endmodule

// File: rtl/evt_wr_ctrl.sv
module evt_wr_ctrl
  import evt_buf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_acc_i,
  input  logic               close_acc_i,
  input  logic               abort_i,
  input  logic [WORD_W-2:0]  wr_data_i,
  input  logic [MADDR_W-1:0] maddr_i,
  output logic               we_o,
  output logic [AW-1:0]      waddr_o,
  output word_t              wdata_o,
  output logic [CNT_W-1:0]   open_cnt_o,
  output logic [TAG_W-1:0]   tag_o
);
  logic [AW-1:0]    hdr_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAG_W-1:0] tag_q;
  hdr_t             hdr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_ptr_q <= '0;
      cnt_q     <= '0;
      tag_q     <= '0;
    end else if (abort_i) begin
      cnt_q <= '0;
    end else if (close_acc_i) begin
      hdr_ptr_q <= hdr_ptr_q + AW'(cnt_q) + AW'(1);
      cnt_q     <= '0;
      tag_q     <= tag_q + TAG_W'(1);
    end else if (data_acc_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    hdr.is_hdr = 1'b1;
    hdr.tag    = tag_q;
    hdr.maddr  = maddr_i;
    hdr.pad    = '0;
    hdr.cnt    = cnt_q;
  end

  // header slot is back-filled at close; data goes after it
  assign we_o       = close_acc_i | data_acc_i;
  assign waddr_o    = close_acc_i ? hdr_ptr_q : hdr_ptr_q + AW'(cnt_q) + AW'(1);
  assign wdata_o    = close_acc_i ? word_t'(hdr) : {1'b0, wr_data_i};
  assign open_cnt_o = cnt_q;
  assign tag_o      = tag_q;
endmodule

// File: rtl/evt_rd_ctrl.sv
module evt_rd_ctrl
  import evt_buf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avail_i,
  input  logic             rd_ready_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] head_cnt_i,
  output logic [AW-1:0]    raddr_o,
  output logic [AW-1:0]    haddr_o,
  output logic             release_o,
  output logic [CNT_W:0]   release_len_o
);
  logic [AW-1:0]    head_q;
  logic [CNT_W-1:0] pos_q;
  logic             at_end, step;

  assign at_end        = pos_q == head_cnt_i;
  assign release_o     = avail_i & (skip_i | (rd_ready_i & at_end));
  assign step          = avail_i & rd_ready_i & ~release_o;
  assign release_len_o = {1'b0, head_cnt_i} + (CNT_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      pos_q  <= '0;
    end else if (release_o) begin
      head_q <= head_q + AW'(release_len_o);
      pos_q  <= '0;
    end else if (step) begin
      pos_q <= pos_q + CNT_W'(1);
    end
  end

  assign raddr_o = head_q + AW'(pos_q);
  assign haddr_o = head_q;
endmodule

// File: rtl/evt_ring_buf.sv
module evt_ring_buf
  import evt_buf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_EVT = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int EW     = $clog2(MAX_EVT + 1),
  localparam int UW     = AW + 1,
  localparam int SW     = UW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MADDR_W-1:0] mod_addr_i,
  input  logic               wr_valid_i,
  input  logic [WORD_W-2:0]  wr_data_i,
  output logic               wr_ready_o,
  input  logic               close_i,
  input  logic               abort_i,
  output logic [WORD_W-1:0]  rd_data_o,
  input  logic               rd_ready_i,
  input  logic               skip_i,
  output logic               evt_avail_o,
  output logic               full_o
);
  logic [EW-1:0]    evt_cnt_q;
  logic [UW-1:0]    used_q;
  logic [CNT_W-1:0] open_cnt;
  logic [TAG_W-1:0] tag_w;
  logic             we;
  logic [AW-1:0]    waddr, raddr, haddr;
  word_t            wdata;
  logic [CNT_W-1:0] head_cnt;
  logic             rel;
  logic [CNT_W:0]   rel_len;
  logic [SW-1:0]    used_ext, open_ext;
  logic             evt_full, room_data, room_close, data_acc, close_acc;
  logic [UW-1:0]    add_w, sub_w;

  assign used_ext   = SW'(used_q);
  assign open_ext   = SW'(open_cnt);
  // one extra word is always held for the open event's header
  assign room_data  = (used_ext + open_ext + SW'(1)) < SW'(DEPTH);
  assign room_close = (used_ext + open_ext) < SW'(DEPTH);
  assign evt_full   = evt_cnt_q == EW'(MAX_EVT);

  assign full_o      = evt_full | ~room_data;
  assign wr_ready_o  = ~full_o;
  assign evt_avail_o = evt_cnt_q != '0;
  assign data_acc    = wr_valid_i & ~close_i & ~abort_i & ~full_o;
  assign close_acc   = close_i & ~abort_i & ~evt_full & room_close;

  assign add_w = close_acc ? UW'(open_cnt) + UW'(1) : '0;
  assign sub_w = rel ? UW'(rel_len) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_cnt_q <= '0;
      used_q    <= '0;
    end else begin
      used_q <= used_q + add_w - sub_w;
      case ({close_acc, rel})
        2'b10:   evt_cnt_q <= evt_cnt_q + EW'(1);
        2'b01:   evt_cnt_q <= evt_cnt_q - EW'(1);
        default: evt_cnt_q <= evt_cnt_q;
      endcase
    end
  end

  evt_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_acc_i (data_acc),
    .close_acc_i(close_acc),
    .abort_i    (abort_i),
    .wr_data_i  (wr_data_i),
    .maddr_i    (mod_addr_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .open_cnt_o (open_cnt),
    .tag_o      (tag_w)
  );

  evt_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .avail_i      (evt_avail_o),
    .rd_ready_i   (rd_ready_i),
    .skip_i       (skip_i),
    .head_cnt_i   (head_cnt),
    .raddr_o      (raddr),
    .haddr_o      (haddr),
    .release_o    (rel),
    .release_len_o(rel_len)
  );

  evt_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rdata_o(rd_data_o),
    .haddr_i(haddr),
    .hcnt_o (head_cnt)
  );
endmodule

// File: rtl/evt_ring_buf_chk.sv
module evt_ring_buf_chk
  import evt_buf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_EVT = 8,
  localparam int EW     = $clog2(MAX_EVT + 1),
  localparam int UW     = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              close_i,
  input logic              abort_i,
  input logic              skip_i,
  input logic              evt_avail_o,
  input logic              full_o,
  input logic              wr_ready_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [TAG_W-1:0]  tag_w,
  input logic [EW-1:0]     evt_cnt_q,
  input logic [UW-1:0]     used_q
);
  always_comb begin
    if (!rst_ni) begin
      // R1
      reset_state_chk: assert (!evt_avail_o && !full_o && wr_ready_o);
    end
  end

  // R5
  commit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_avail_o) |-> $past(close_i && !abort_i));

  // R6
  abort_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> $stable(tag_w));

  // R4
  tag_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_w != $past(tag_w)) |-> (tag_w == TAG_W'($past(tag_w) + 1'b1)));

  // R7
  skip_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i && evt_avail_o) |=> (!evt_avail_o || rd_data_o[WORD_W-1]));

  // R8
  evt_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_cnt_q <= EW'(MAX_EVT)) && ((evt_cnt_q == EW'(MAX_EVT)) -> full_o));

  // R9
  word_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= UW'(DEPTH));
endmodule

bind evt_ring_buf evt_ring_buf_chk #(.DEPTH(DEPTH), .MAX_EVT(MAX_EVT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .close_i    (close_i),
  .abort_i    (abort_i),
  .skip_i     (skip_i),
  .evt_avail_o(evt_avail_o),
  .full_o     (full_o),
  .wr_ready_o (wr_ready_o),
  .rd_data_o  (rd_data_o),
  .tag_w      (tag_w),
  .evt_cnt_q  (evt_cnt_q),
  .used_q     (used_q)
);

// File: tb/evt_ring_buf_bench.sv
module evt_ring_buf_bench;
  localparam int DEPTH   = 64;
  localparam int MAX_EVT = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  mod_addr = 5'd5;
  logic        wr_valid = 0, close = 0, abort = 0, rd_ready = 0, skip = 0;
  logic [30:0] wr_data = '0;
  logic        wr_ready, evt_avail, full;
  logic [31:0] rd_data;

  int n_cmp = 0, n_bad = 0, cyc_n = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_ring_buf #(.DEPTH(DEPTH), .MAX_EVT(MAX_EVT)) u_evt_ring_buf (
    .clk_i(clk), .rst_ni(rst_n), .mod_addr_i(mod_addr),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .close_i(close), .abort_i(abort), .rd_data_o(rd_data),
    .rd_ready_i(rd_ready), .skip_i(skip), .evt_avail_o(evt_avail), .full_o(full)
  );

  // reference model
  logic [31:0] m_words[$];
  int          m_len[$];
  logic [30:0] m_open[$];
  int          m_tag = 0, m_used = 0;

  function automatic logic [31:0] hdr(int tag, int maddr, int cnt);
    return {1'b1, 4'(tag), 5'(maddr), 15'd0, 7'(cnt)};
  endfunction

  function automatic bit m_full();
    return (m_len.size() == MAX_EVT) || (m_used + m_open.size() + 1 >= DEPTH);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_words.delete(); m_len.delete(); m_open.delete();
      m_tag = 0; m_used = 0;
    end else begin
      bit f, closed, dacc;
      f      = m_full();
      closed = close && !abort && (m_len.size() < MAX_EVT) && (m_used + m_open.size() < DEPTH);
      dacc   = wr_valid && !close && !abort && !f;
      if (m_len.size() > 0) begin
        if (skip) begin
          repeat (m_len[0]) void'(m_words.pop_front());
          m_used -= m_len[0];
          void'(m_len.pop_front());
        end else if (rd_ready) begin
          void'(m_words.pop_front());
          m_used--;
          m_len[0]--;
          if (m_len[0] == 0) void'(m_len.pop_front());
        end
      end
      if (abort) m_open.delete();
      else if (closed) begin
        m_words.push_back(hdr(m_tag, mod_addr, m_open.size()));
        foreach (m_open[i]) m_words.push_back({1'b0, m_open[i]});
        m_len.push_back(m_open.size() + 1);
        m_used += m_open.size() + 1;
        m_tag = (m_tag + 1) % 16;
        m_open.delete();
      end else if (dacc) m_open.push_back(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10", "evt_avail", 32'(evt_avail), 32'(m_len.size() > 0));
      chk("R8 R9", "full", 32'(full), 32'(m_full()));
      chk("R9", "wr_ready", 32'(wr_ready), 32'(!m_full()));
      if (m_len.size() > 0) chk("R2 R3", "rd_data", rd_data, m_words[0]);
    end
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 20000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cyc(bit v, logic [30:0] d, bit c, bit a, bit rr, bit sk);
    wr_valid = v; wr_data = d; close = c; abort = a; rd_ready = rr; skip = sk;
    @(negedge clk);
  endtask

  task automatic put(logic [30:0] d); cyc(1, d, 0, 0, 0, 0); endtask
  task automatic shut();              cyc(0, 0, 1, 0, 0, 0); endtask
  task automatic pop();               cyc(0, 0, 0, 0, 1, 0); endtask
  task automatic skp();               cyc(0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "avail in reset", 32'(evt_avail), 0);
    chk("R1", "full in reset", 32'(full), 0);
    chk("R1", "ready in reset", 32'(wr_ready), 1);
    rst_n = 1;
    @(negedge clk);

    // basic event, tag 0
    put(31'h11); put(31'h22); put(31'h33);
    chk("R5", "open event hidden", 32'(evt_avail), 0);
    shut();
    chk("R5", "visible after close", 32'(evt_avail), 1);
    chk("R3", "header", rd_data, hdr(0, 5, 3));
    pop(); chk("R2", "data0", rd_data, {1'b0, 31'h11});
    pop(); chk("R2", "data1", rd_data, {1'b0, 31'h22});
    pop(); chk("R2", "data2", rd_data, {1'b0, 31'h33});
    pop(); chk("R10", "drained", 32'(evt_avail), 0);

    // empty event, tag 1
    shut(); chk("R4", "empty header", rd_data, hdr(1, 5, 0));
    pop();  chk("R10", "drained empty", 32'(evt_avail), 0);

    // abort keeps tag 2
    put(31'h44); put(31'h55); cyc(0, 0, 0, 1, 0, 0);
    chk("R6", "abort hidden", 32'(evt_avail), 0);
    put(31'h66); shut();
    chk("R6", "tag after abort", rd_data, hdr(2, 5, 1));
    pop(); chk("R6", "post-abort data", rd_data, {1'b0, 31'h66});
    pop();

    // skip mid-event, tags 3 and 4
    put(31'ha1); put(31'ha2); shut(); put(31'hb1); shut();
    chk("R3", "first header", rd_data, hdr(3, 5, 2));
    pop(); chk("R2", "first data", rd_data, {1'b0, 31'ha1});
    skp(); chk("R7", "skip to next header", rd_data, hdr(4, 5, 1));
    skp(); chk("R7", "skip last", 32'(evt_avail), 0);

    // event-count limit, tags 5..12, extra close ignored
    for (int i = 0; i < MAX_EVT; i++) shut();
    chk("R8", "full at limit", 32'(full), 1);
    chk("R8", "not ready at limit", 32'(wr_ready), 0);
    shut();
    skp(); chk("R8", "room after skip", 32'(full), 0);
    shut();
    for (int i = 0; i < MAX_EVT; i++) begin
      chk("R8", "head tag", rd_data, hdr(6 + i, 5, 0));
      skp();
    end
    chk("R8", "drained limit", 32'(evt_avail), 0);

    // word limit, tag 14
    mod_addr = 5'd17;
    for (int i = 0; i < 70; i++) put(31'(i + 1));
    chk("R9", "full on words", 32'(full), 1);
    shut(); chk("R9", "count capped", rd_data, hdr(14, 17, 63));
    pop();  chk("R9", "first big data", rd_data, {1'b0, 31'd1});
    skp();  chk("R10", "big skipped", 32'(evt_avail), 0);

    // close with data, tag 15; abort beats close; wrap to 0
    mod_addr = 5'd5;
    put(31'h77); cyc(1, 31'h88, 1, 0, 0, 0);
    chk("R11", "data with close dropped", rd_data, hdr(15, 5, 1));
    pop(); chk("R11", "kept data", rd_data, {1'b0, 31'h77});
    pop();
    cyc(0, 0, 1, 1, 0, 0);
    chk("R11", "abort beats close", 32'(evt_avail), 0);
    shut(); chk("R4", "tag wrap", rd_data, hdr(0, 5, 0));
    pop();
    cyc(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule